// File: doc/BRIEF.md
# Gray-Code Scanned Probe Multiplexer

This block lets an external reader look at a wide vector of internal probe signals one bit at a time without putting any scan or observer flip-flop inside the logic being watched. The probes feed the leaves of a balanced binary multiplexer tree. A select register steps through the leaf addresses in reflected Gray-code order. The selected bit is registered and presented on a single serial read line, so a host clocking the scan port gets the probes back in a fixed order that it knows in advance.

Each tree level is steered by exactly one bit of the select register, and that bit drives no other level. Because the select advances in Gray code, only one level changes its steering on each step. The tree therefore settles through a single path per step, and the select lines toggle far less often than a binary counter would make them toggle. The probe count is a parameter. The select width is the base-2 logarithm of the probe count, rounded up. Leaves above the last probe read as zero. A restart strobe returns the scan to the first address, and a one-cycle flag marks the end of every complete pass through the address space.

The read path is purely observational. It shares no shift chain with any write path and does no crossing from the probed logic's clock domain: the probes are sampled as they stand at the scan clock edge.

Top module: `gray_probe_scan`

## Requirements
- R1: While `rst_n` is low, `sel_code` is 0, `rd_bit` is 0 and `frame_done` is 0.
- R2: On a clock edge with `scan_en`=1 and `restart`=0, `sel_code` moves from the code of step i to the code of step i+1 (modulo 2^SEL_W), where step i has code i XOR (i>>1). Exactly one bit of `sel_code` changes.
- R3: On a clock edge with `scan_en`=0 and `restart`=0, `sel_code` keeps its value.
- R4: On a clock edge with `restart`=1, `sel_code` becomes 0 whatever `scan_en` is, and `frame_done` is 0 after that edge.
- R5: After every clock edge, `rd_bit` equals `probes[a]`, where a is the value `sel_code` held just before the edge. Bit l of `sel_code` steers level l of the tree, with bit 0 at the leaf level, so the leaf address equals the select value.
- R6: A leaf address a with a >= N_PROBES reads as 0 on `rd_bit`.
- R7: When an enabled, non-restart edge takes `sel_code` from the last code of the sequence (only bit SEL_W-1 set) back to 0, `frame_done` is 1 for the following cycle only. At every other edge it is 0.
- R8: Starting from a restart, 2^SEL_W enabled steps visit every select code exactly once and return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_en | input | 1 | Advance the select by one Gray step on this edge |
| restart | input | 1 | Force the select to code 0 on this edge; takes priority |
| probes | input | N_PROBES | Internal signals being observed |
| rd_bit | output | 1 | Registered bit of the selected probe |
| sel_code | output | SEL_W | Current Gray-coded leaf address |
| frame_done | output | 1 | One-cycle pulse after the wrap to code 0 |

## Verification
On every cycle, the assertions check the single-bit change per enabled step, the hold when idle, the restart to zero, the one-cycle latency from select to read bit against a zero-padded probe vector, and the match between the sequencer's wrap event and `frame_done`. Two properties need the bench's scenarios with a known history: that the codes follow the reflected Gray order itself, and that a pass started by a restart covers every address exactly once before the wrap. The same holds for the zero reading of the padding leaves, which the bench shows with all probes driven high.

// File: rtl/gps_pkg.sv
package gps_pkg;

  // Select width for a given probe count (at least one bit).
  function automatic int unsigned sel_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Offset of tree level 'lvl' inside a flat node vector, leaves at level 0.
  function automatic int unsigned lvl_off(input int unsigned leaves, input int unsigned lvl);
    return 2 * leaves - 2 * (leaves >> lvl);
  endfunction

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/gps_gray_seq.sv
module gps_gray_seq #(
  parameter int unsigned SEL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             restart,
  output logic [SEL_W-1:0] sel_q,
  output logic             step_fire,
  output logic             wrap_fire
);
  import gps_pkg::*;

  localparam logic [SEL_W-1:0] LAST_CODE = SEL_W'(1) << (SEL_W - 1);

  logic [SEL_W-1:0] bin_now;
  logic [SEL_W-1:0] bin_nxt;
  logic [SEL_W-1:0] gray_nxt;

  always_comb begin
    bin_now  = SEL_W'(gray_to_bin(32'(sel_q)));
    bin_nxt  = bin_now + SEL_W'(1);
    gray_nxt = SEL_W'(bin_to_gray(32'(bin_nxt)));
  end

  assign step_fire = step_en && !restart;
  assign wrap_fire = step_fire && (sel_q == LAST_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_q <= '0;
    else if (restart)   sel_q <= '0;
    else if (step_en)   sel_q <= gray_nxt;
  end

endmodule

// File: rtl/gps_mux_tree.sv
module gps_mux_tree #(
  parameter int unsigned N_PROBES = 37,
  parameter int unsigned SEL_W    = 6
) (
  input  logic [N_PROBES-1:0] probes,
  input  logic [SEL_W-1:0]    sel,
  output logic                leaf_o
);
  import gps_pkg::*;

  localparam int unsigned LEAVES = 1 << SEL_W;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic [NODES-1:0] node;

  // Leaf level: real probes, padding tied low.
  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < N_PROBES) begin : g_real
      assign node[j] = probes[j];
    end else begin : g_pad
      assign node[j] = 1'b0;
    end
  end

  // Each level l is steered by sel[l] only.
  for (genvar l = 0; l < SEL_W; l++) begin : g_lvl
    localparam int unsigned IN_OFF  = lvl_off(LEAVES, l);
    localparam int unsigned OUT_OFF = lvl_off(LEAVES, l + 1);
    localparam int unsigned OUT_CNT = LEAVES >> (l + 1);
    for (genvar j = 0; j < OUT_CNT; j++) begin : g_mux
      assign node[OUT_OFF + j] = sel[l] ? node[IN_OFF + 2*j + 1] : node[IN_OFF + 2*j];
    end
  end

  assign leaf_o = node[NODES-1];

endmodule

// File: rtl/gps_out_stage.sv
module gps_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic leaf_i,
  input  logic wrap_i,
  output logic rd_bit,
  output logic frame_done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bit     <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      rd_bit     <= leaf_i;
      frame_done <= wrap_i;
    end
  end

endmodule

// File: rtl/gray_probe_scan.sv
module gray_probe_scan #(
  parameter int unsigned N_PROBES = 37,
  parameter int unsigned SEL_W    = gps_pkg::sel_width(N_PROBES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scan_en,
  input  logic                restart,
  input  logic [N_PROBES-1:0] probes,
  output logic                rd_bit,
  output logic [SEL_W-1:0]    sel_code,
  output logic                frame_done
);

  logic step_fire;
  logic wrap_fire;
  logic tree_leaf;

  gps_gray_seq #(.SEL_W(SEL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (scan_en),
    .restart   (restart),
    .sel_q     (sel_code),
    .step_fire (step_fire),
    .wrap_fire (wrap_fire)
  );

  gps_mux_tree #(.N_PROBES(N_PROBES), .SEL_W(SEL_W)) u_tree (
    .probes (probes),
    .sel    (sel_code),
    .leaf_o (tree_leaf)
  );

  gps_out_stage u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .leaf_i     (tree_leaf),
    .wrap_i     (wrap_fire),
    .rd_bit     (rd_bit),
    .frame_done (frame_done)
  );

endmodule

// File: rtl/gps_scan_chk.sv
module gps_scan_chk #(
  parameter int unsigned N_PROBES = 37,
  parameter int unsigned SEL_W    = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scan_en,
  input logic                restart,
  input logic [N_PROBES-1:0] probes,
  input logic                rd_bit,
  input logic [SEL_W-1:0]    sel_code,
  input logic                frame_done,
  input logic                step_fire,
  input logic                wrap_fire
);

  localparam int unsigned LEAVES = 1 << SEL_W;

  logic [LEAVES-1:0] padded;
  assign padded = LEAVES'(probes);

  // R1: reset values
  always_comb begin
    if (!rst_n) begin
      a_reset_r1: assert (sel_code == '0 && !frame_done && !rd_bit)
        else $error("reset state wrong");
    end
  end

  p_one_bit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> $countones(sel_code ^ $past(sel_code)) == 1);

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !restart) |=> $stable(sel_code));

  p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (sel_code == '0) && !frame_done);

  // R5 and R6: read bit is the padded leaf of the previous select
  p_read_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> rd_bit == $past(padded[sel_code]));

  p_frame_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> frame_done == $past(wrap_fire));

  p_wrap_to_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_fire |=> sel_code == '0);

endmodule

bind gray_probe_scan gps_scan_chk #(.N_PROBES(N_PROBES), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scan_en    (scan_en),
  .restart    (restart),
  .probes     (probes),
  .rd_bit     (rd_bit),
  .sel_code   (sel_code),
  .frame_done (frame_done),
  .step_fire  (step_fire),
  .wrap_fire  (wrap_fire)
);

// File: tb/sim_gray_probe_scan.sv
`timescale 1ns/1ps
module sim_gray_probe_scan;
  localparam int N  = 37;
  localparam int W  = 6;
  localparam int LV = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         scan_en = 1'b0;
  logic         restart = 1'b0;
  logic [N-1:0] probes = '0;
  logic         rd_bit;
  logic [W-1:0] sel_code;
  logic         frame_done;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gray_probe_scan #(.N_PROBES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .restart(restart),
    .probes(probes), .rd_bit(rd_bit), .sel_code(sel_code), .frame_done(frame_done)
  );

  // Behavioural reference: position counter, Gray code by arithmetic.
  int m_pos = 0;
  int m_rd  = 0;
  int m_fd  = 0;

  function automatic int gray_of(input int p);
    return p ^ (p / 2);
  endfunction

  function automatic int probe_at(input int a, input logic [N-1:0] pv);
    if (a >= N) return 0;
    return int'(pv[a]);
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      m_rd <= probe_at(gray_of(m_pos), probes);
      m_fd <= (scan_en && !restart && m_pos == LV - 1) ? 1 : 0;
      if (restart)      m_pos <= 0;
      else if (scan_en) m_pos <= (m_pos + 1) % LV;
    end
  end

  // Inputs applied before the edge being compared
  bit           last_en = 0, last_rs = 0;
  int           prev_sel = 0;
  int           prev_exp_addr = 0;
  bit           clean = 0;
  logic [LV-1:0] seen = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    int exp_sel;
    exp_sel = gray_of(m_pos);
    if (last_rs)      chk(int'(sel_code) == exp_sel, "R4 sel after restart", sel_code, exp_sel);
    else if (last_en) chk(int'(sel_code) == exp_sel, "R2 sel after step", sel_code, exp_sel);
    else              chk(int'(sel_code) == exp_sel, "R3 sel held", sel_code, exp_sel);
    if (last_en && !last_rs)
      chk($countones(W'(sel_code) ^ W'(prev_sel)) == 1, "R2 hamming",
          $countones(W'(sel_code) ^ W'(prev_sel)), 1);
    if (prev_exp_addr >= N) chk(int'(rd_bit) == m_rd, "R6 pad leaf", rd_bit, m_rd);
    else                    chk(int'(rd_bit) == m_rd, "R5 read bit", rd_bit, m_rd);
    chk(int'(frame_done) == m_fd, "R7 frame flag", frame_done, m_fd);
    // R8 coverage of one pass started from restart
    if (last_rs) begin
      clean = 1;
      seen  = '0;
      seen[sel_code] = 1'b1;
    end else if (last_en && !frame_done) begin
      seen[sel_code] = 1'b1;
    end
    if (frame_done && clean) begin
      chk($countones(seen) == LV && sel_code == '0, "R8 full pass", $countones(seen), LV);
      clean = 0;
    end
    prev_sel      = int'(sel_code);
    prev_exp_addr = int'(sel_code);
  endtask

  task automatic cycle(input bit en, input bit rs, input bit rnd);
    @(negedge clk);
    compare();
    scan_en = en;
    restart = rs;
    if (rnd) probes = {$urandom(), $urandom()};
    last_en = en;
    last_rs = rs;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    probes = {$urandom(), $urandom()};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sel_code == '0, "R1 sel", sel_code, 0);
    chk(rd_bit == 1'b0, "R1 rd", rd_bit, 0);
    chk(frame_done == 1'b0, "R1 frame", frame_done, 0);
    rst_n = 1'b1;
    // Full passes with changing probes (R2 R5 R7 R8)
    cycle(0, 1, 1);
    for (int i = 0; i < 3 * LV; i++) cycle(1, 0, 1);
    // All probes high: pad leaves must still read 0 (R6)
    probes = '1;
    cycle(0, 1, 0);
    for (int i = 0; i < LV + 2; i++) cycle(1, 0, 0);
    // Idle holds (R3)
    for (int i = 0; i < 10; i++) cycle(0, 0, 1);
    // Restart without enable, then restart mid-pass (R4)
    for (int i = 0; i < 5; i++) cycle(1, 0, 1);
    cycle(0, 1, 1);
    for (int i = 0; i < 20; i++) cycle(1, 0, 1);
    cycle(1, 1, 1);
    for (int i = 0; i < LV; i++) cycle(1, 0, 1);
    // Mixed stimulus
    for (int i = 0; i < 1500; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cycle(r < 70, r >= 97, 1);
    end
    cycle(0, 0, 0);
    cycle(0, 0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule